// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer reached through four 16-bit registers. Software chooses a timeout in half-second units and turns counting on. A turn-on cannot be undone. To keep the system alive, software writes a two-word key pair to a service register. If the count runs out, the block raises one of two reset requests and holds it:

- an internal reset request, or
- an active-low reset pin meant for an external supervisor.

An optional pre-timeout interrupt can warn software before expiry. A lead count sets how early the warning comes.

A second watchdog for the boot phase starts from reset with a fixed window. It drives the same reset outputs. Boot firmware is expected to switch it off, and once off it cannot be brought back.

The time base comes from outside as a single-cycle tick-enable pulse. Each tick stands for half a second. Register writes are single-cycle strobes. Reads are combinational on the address. The registers and their addresses are:

| Address | Register |
|---|---|
| 0 | control |
| 1 | service |
| 2 | interrupt control |
| 3 | misc control |

Top module: `wdk_top`

## Requirements
- R1: After reset, the registers read as follows:
  - control (address 0) reads 16'h0000;
  - interrupt control (address 2) reads 16'h0000;
  - misc control (address 3) reads 16'h0001;
  - service (address 1) always reads 16'h0000.
  
  After reset, int_rst_req is 0, ext_rst_n is 1 and irq is 0.
- R2: Control bits [15:8] hold the timeout field T, and bit 0 is the enable bit. Writing the enable bit as 1 while counting is off loads T from the same write. After that, the reset request appears on the (T+1)-th tick, so T = 2·seconds−1 gives the timeout in seconds. Without the enable bit, the main counter never expires.
- R3: The counter reloads with the current T in two cases:
  - a write of 16'h5555 to address 1 is followed directly by a write of 16'hAAAA to address 1;
  - any other value written in between, or 16'hAAAA written alone, does not reload and clears the pending first key.
- R4: Once control bit 0 is 1, a later control write with bit 0 = 0 leaves it at 1. The other control fields take the written values.
- R5: Control bit 1 selects the external reset path.
  - If bit 1 is 1 when the watchdog expires, ext_rst_n goes low and int_rst_req stays 0.
  - If bit 1 is 0, int_rst_req goes high and ext_rst_n stays 1.
- R6: Interrupt-control bit 0 enables the pre-timeout interrupt, and bits [15:8] hold the lead count L. On the tick at which the running count equals L, the status bit (interrupt-control bit 1) and irq are set. With L = 0, this happens on the same edge as the reset output.
- R7: Writing interrupt control with bit 1 = 1 clears the status bit and irq.
- R8: Rewriting T while the counter runs does not change the current countdown. The new T is used from the next successful service onward.
- R9: The boot watchdog is enabled by misc-control bit 0, which is 1 out of reset.
  - While enabled, it expires on the 32nd tick and asserts the same reset output as the main counter.
  - Writing bit 0 as 0 stops it for good; a later write of 1 has no effect.
- R10: A reset output, once asserted, stays asserted until rst is applied. Ticks and key writes in that time have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick_en | input | 1 | Half-second time-base pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq | output | 1 | Pre-timeout interrupt (level, follows the status bit) |
| int_rst_req | output | 1 | Internal reset request, sticky until rst |
| ext_rst_n | output | 1 | Active-low external reset, sticky until rst |

## Verification
Every output comes from a register, and the registers update on the same clock edge as the tick or write that causes them:
- counter reloads on the edge that takes the second key or the enabling control write;
- reset outputs and the pre-timeout status bit change on the edge of the expiring or matching tick;
- read data follows the address with no delay.

The bench drives inputs on the falling edge and compares every output against a behavioural model one time unit after each rising edge. Directed checks are made only after the counted number of ticks has been applied, so each check lands on the cycle the result is due.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int DATA_W = 16;
    localparam int TMO_W  = 8;
    localparam int LEAD_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_SVC  = 2'd1,
        RA_ICR  = 2'd2,
        RA_MISC = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             ext_sel;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic [LEAD_W-1:0] lead;
        logic              stat;
        logic              irq_en;
    } icr_t;

    typedef struct packed {
        logic             load;
        logic [TMO_W-1:0] val;
    } reload_t;

    function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
        return {c.tmo, {(DATA_W-TMO_W-2){1'b0}}, c.ext_sel, c.en};
    endfunction

    function automatic logic [DATA_W-1:0] icr_word(icr_t i);
        return {i.lead, {(DATA_W-LEAD_W-2){1'b0}}, i.stat, i.irq_en};
    endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pre_hit,
    output ctrl_t             ctrl,
    output icr_t              icr,
    output logic              pd_en,
    output reload_t           rld,
    output logic [DATA_W-1:0] rdata
);

    logic wr_ctrl, wr_svc, wr_icr, wr_misc;
    logic armed;
    logic start_load, svc_ok, stat_set;

    assign wr_ctrl = wr_en && (addr == RA_CTRL);
    assign wr_svc  = wr_en && (addr == RA_SVC);
    assign wr_icr  = wr_en && (addr == RA_ICR);
    assign wr_misc = wr_en && (addr == RA_MISC);

    assign svc_ok     = wr_svc && armed && (wdata == KEY_SECOND);
    assign start_load = wr_ctrl && wdata[0] && !ctrl.en;
    assign stat_set   = pre_hit && icr.irq_en;

    always_comb begin
        rld.load = svc_ok || start_load;
        rld.val  = start_load ? wdata[DATA_W-1 -: TMO_W] : ctrl.tmo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            icr   <= '0;
            pd_en <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.tmo     <= wdata[DATA_W-1 -: TMO_W];
                ctrl.ext_sel <= wdata[1];
                ctrl.en      <= ctrl.en | wdata[0];
            end
            if (wr_icr) begin
                icr.lead   <= wdata[DATA_W-1 -: LEAD_W];
                icr.irq_en <= wdata[0];
            end
            if (stat_set)
                icr.stat <= 1'b1;
            else if (wr_icr && wdata[1])
                icr.stat <= 1'b0;
            if (wr_misc && !wdata[0])
                pd_en <= 1'b0;
            if (wr_svc)
                armed <= (wdata == KEY_FIRST);
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL: rdata = ctrl_word(ctrl);
            RA_ICR:  rdata = icr_word(icr);
            RA_MISC: rdata = {{(DATA_W-1){1'b0}}, pd_en};
            default: rdata = '0;
        endcase
    end

    p_en_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> ctrl.en);

    p_pd_off_r9: assert property (@(posedge clk) disable iff (rst)
        !pd_en |=> !pd_en);

    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_icr && wdata[1] && !stat_set) |=> !icr.stat);

endmodule

// File: rtl/wdk_main_cnt.sv
module wdk_main_cnt
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              fired,
    input  reload_t           rld,
    input  logic [LEAD_W-1:0] lead,
    output logic              expire,
    output logic              pre_hit
);

    logic [TMO_W-1:0] cnt;
    logic             live;

    assign live    = en && tick && !fired && !rld.load;
    assign expire  = live && (cnt == '0);
    assign pre_hit = live && (LEAD_W'(cnt) == lead);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!fired) begin
            if (rld.load)
                cnt <= rld.val;
            else if (en && tick && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (rld.load && !fired) |=> (cnt == $past(rld.val)));

endmodule

// File: rtl/wdk_pd_cnt.sv
module wdk_pd_cnt #(
    parameter int PD_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_en,
    input  logic tick,
    input  logic fired,
    output logic expire
);

    localparam int PW = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
    localparam logic [PW-1:0] START = PW'(PD_TICKS - 1);

    logic [PW-1:0] cnt;

    assign expire = pd_en && tick && !fired && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= START;
        else if (pd_en && tick && !fired && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!pd_en || !tick) |=> $stable(cnt));

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int PD_TICKS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        int_rst_req,
    output logic        ext_rst_n
);

    ctrl_t   ctrl;
    icr_t    icr;
    reload_t rld;
    logic    pd_en, pre_hit, main_exp, pd_exp;
    logic    fired_q, ext_q;

    wdk_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pre_hit(pre_hit), .ctrl(ctrl), .icr(icr), .pd_en(pd_en),
        .rld(rld), .rdata(rdata)
    );

    wdk_main_cnt u_main (
        .clk(clk), .rst(rst), .en(ctrl.en), .tick(tick_en), .fired(fired_q),
        .rld(rld), .lead(icr.lead), .expire(main_exp), .pre_hit(pre_hit)
    );

    wdk_pd_cnt #(.PD_TICKS(PD_TICKS)) u_pd (
        .clk(clk), .rst(rst), .pd_en(pd_en), .tick(tick_en),
        .fired(fired_q), .expire(pd_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= 1'b0;
            ext_q   <= 1'b0;
        end else if (!fired_q && (main_exp || pd_exp)) begin
            fired_q <= 1'b1;
            ext_q   <= ctrl.ext_sel;
        end
    end

    assign int_rst_req = fired_q && !ext_q;
    assign ext_rst_n   = !(fired_q && ext_q);
    assign irq         = icr.stat;

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (int_rst_req || !ext_rst_n) |=> ($stable(int_rst_req) && $stable(ext_rst_n)));

    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(int_rst_req && !ext_rst_n));

    p_lead0_r6: assert property (@(posedge clk) disable iff (rst)
        (main_exp && icr.irq_en && icr.lead == '0) |=> (irq && (int_rst_req || !ext_rst_n)));

endmodule

// File: tb/sim_wdk_top.sv
module sim_wdk_top;

    localparam int CLK_PERIOD = 10;
    localparam int PD_N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq, int_rst_req, ext_rst_n;

    int checks = 0;
    int errors = 0;

    wdk_top #(.PD_TICKS(PD_N)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .int_rst_req(int_rst_req),
        .ext_rst_n(ext_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit       m_en, m_ext, m_armed, m_ien, m_stat, m_pden, m_fired, m_fext;
    bit [7:0] m_tmo, m_lead;
    int       m_cnt, m_pd;

    task automatic model_reset();
        m_en = 0; m_ext = 0; m_tmo = 0; m_cnt = 0; m_armed = 0;
        m_ien = 0; m_lead = 0; m_stat = 0; m_pden = 1; m_pd = PD_N - 1;
        m_fired = 0; m_fext = 0;
    endtask

    task automatic model_step();
        bit load, mexp, phit, pexp, live;
        int lval;
        load = 0; lval = 0;
        if (wr_en && addr == 2'd1 && m_armed && wdata == 16'hAAAA) begin
            load = 1; lval = int'(m_tmo);
        end
        if (wr_en && addr == 2'd0 && wdata[0] && !m_en) begin
            load = 1; lval = int'(wdata[15:8]);
        end
        live = m_en && tick_en && !m_fired && !load;
        mexp = live && m_cnt == 0;
        phit = live && m_cnt == int'(m_lead);
        pexp = m_pden && tick_en && !m_fired && m_pd == 0;
        if (!m_fired) begin
            if (load) m_cnt = lval;
            else if (m_en && tick_en && m_cnt > 0) m_cnt = m_cnt - 1;
            if (m_pden && tick_en && m_pd > 0) m_pd = m_pd - 1;
        end
        if (!m_fired && (mexp || pexp)) begin
            m_fired = 1; m_fext = m_ext;
        end
        if (phit && m_ien) m_stat = 1;
        else if (wr_en && addr == 2'd2 && wdata[1]) m_stat = 0;
        if (wr_en) begin
            case (addr)
                2'd0: begin m_tmo = wdata[15:8]; m_ext = wdata[1]; m_en = m_en | wdata[0]; end
                2'd1: m_armed = (wdata == 16'h5555);
                2'd2: begin m_lead = wdata[15:8]; m_ien = wdata[0]; end
                default: if (!wdata[0]) m_pden = 0;
            endcase
        end
    endtask

    function automatic logic [15:0] model_rd(logic [1:0] a);
        case (a)
            2'd0: return {m_tmo, 6'b0, m_ext, m_en};
            2'd2: return {m_lead, 6'b0, m_stat, m_ien};
            2'd3: return {15'b0, m_pden};
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check("R5 int_rst_req", {15'b0, int_rst_req}, {15'b0, m_fired && !m_fext});
            check("R5 ext_rst_n",  {15'b0, ext_rst_n},  {15'b0, !(m_fired && m_fext)});
            check("R6 irq",        {15'b0, irq},        {15'b0, m_stat});
            check("R4 rdata",      rdata,               model_rd(addr));
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1; wr_en = 0; tick_en = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1;
            @(negedge clk); tick_en = 0;
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic chk_rst(string tag, bit i_exp, bit e_exp);
        check(tag, {14'b0, int_rst_req, ext_rst_n}, {14'b0, i_exp, e_exp});
    endtask

    logic done = 1'b0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        do_reset();
        // R1 reset values
        rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); check("R1 svc", v, 16'h0000);
        rd(2'd2, v); check("R1 icr", v, 16'h0000);
        rd(2'd3, v); check("R1 misc", v, 16'h0001);
        chk_rst("R1 outputs", 0, 1);
        check("R1 irq", {15'b0, irq}, 16'h0);

        // R9 boot watchdog expiry on the 32nd tick
        ticks(PD_N - 1); chk_rst("R9 before", 0, 1);
        ticks(1);        chk_rst("R9 expiry", 1, 1);

        // R9 disable is permanent, R2 timeout
        do_reset();
        wr(2'd3, 16'h0000); wr(2'd3, 16'h0001);
        rd(2'd3, v); check("R9 no re-enable", v, 16'h0000);
        ticks(40); chk_rst("R2 idle not enabled", 0, 1);
        wr(2'd0, 16'h0301);
        ticks(3); chk_rst("R2 before", 0, 1);
        ticks(1); chk_rst("R2 expiry int R5", 1, 1);
        wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA); ticks(10);
        chk_rst("R10 held", 1, 1);
        do_reset();
        chk_rst("R10 released", 0, 1);

        // R3 key sequence
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0501);
        ticks(4);
        wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA);
        ticks(5); chk_rst("R3 serviced", 0, 1);
        wr(2'd1, 16'h5555); wr(2'd1, 16'h1234); wr(2'd1, 16'hAAAA);
        ticks(1); chk_rst("R3 broken pair", 1, 1);

        // R4 sticky enable, R8 deferred timeout, R3 lone key, R5 ext path
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0701);
        wr(2'd0, 16'h0202);
        rd(2'd0, v); check("R4 sticky", v, 16'h0203);
        ticks(7); chk_rst("R8 old count", 0, 1);
        wr(2'd1, 16'hAAAA);
        wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA);
        ticks(2); chk_rst("R8 new count", 0, 1);
        ticks(1); chk_rst("R5 ext expiry", 0, 0);

        // R6 pre-timeout, R7 clear
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h0201);
        wr(2'd0, 16'h0401);
        ticks(2); check("R6 not yet", {15'b0, irq}, 16'h0);
        ticks(1); check("R6 hit", {15'b0, irq}, 16'h1);
        rd(2'd2, v); check("R6 status", v, 16'h0203);
        wr(2'd2, 16'h0203);
        check("R7 cleared", {15'b0, irq}, 16'h0);
        ticks(1); chk_rst("R6 pending", 0, 1);
        ticks(1); chk_rst("R6 expiry", 1, 1);
        check("R7 stays clear", {15'b0, irq}, 16'h0);

        // R6 lead zero coincides with reset
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h0103);
        ticks(1); check("R6 lead0 early", {15'b0, irq, ext_rst_n}, 16'h1);
        ticks(1); check("R6 lead0 together", {15'b0, irq, ext_rst_n}, 16'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule